// File: doc/BRIEF.md
# Double-Buffered Programmable Pulse Generator

This block produces a repeating rectangular waveform from an 8-bit up-counter and two compare values. The counter advances once for each tick on the enable input. One compare value, the span, fixes the full period: when the incremented count equals it, the counter returns to zero and the output flips. The other, the duty value, fixes where inside the period the output flips a second time. Both flips come from one toggling flip-flop, so the pair of compares sets the pulse width and the repetition rate.

Software reaches the block through a simple write port with three targets: the duty value, the span value and a control word. The control word holds a run bit, a double-buffer enable and a two-bit output mode. With double buffering on, a new duty value is parked in a holding register and copied into the live compare only when the span match ends a period, so a duty change never splits a pulse. With it off, the live compare follows the write at once.

A two-state controller, IDLE and RUN, gates the counter. The transition START (IDLE to RUN) is taken on the clock after the run bit is seen set; the transition HALT (RUN to IDLE) is taken on the clock after it is seen clear. IDLE holds on a clear run bit and RUN holds on a set one. Counting happens only in RUN while the run bit is still set.

Top module: `ppg_top`

## Requirements
- R1: After reset the output is 0, all registers read as zero and the counter is stopped.
- R2: The counter advances only in cycles where the tick input is 1 while running; cycles with tick 0 shift the whole waveform later without changing its shape in ticks.
- R3: When the incremented count equals the live duty value (and not the span), the output toggles at that clock edge.
- R4: When the incremented count equals the span value, the output toggles and the counter returns to zero, so a span of P gives a period of P ticks.
- R5: With double buffering on (control bit 1 = 1), a write to the duty target (select 0) goes to a holding register and reaches the live compare only at the next span match.
- R6: With double buffering off, a write to the duty target updates the live compare in the same clock edge.
- R7: The output mode is control bits 3:2: 2'b11 presets the output to 1 and enables toggling, 2'b10 presets it to 0 and enables toggling (a low-going pulse), 2'b00 or 2'b01 neither presets nor toggles. The preset takes effect at the control write edge (select 2).
- R8: Clearing the run bit (control bit 0) clears and stops the counter; setting it again restarts counting from zero.
- R9: While stopped, the output keeps its value and no transfer from the holding register to the live compare occurs.
- R10: If the duty value is equal to or greater than the span, only span matches toggle the output.
- R11: A duty write in the same cycle as a span match, with double buffering on, moves the previously held value into the live compare; the newly written value takes effect one period later.
- R12: With a span of 0x50, a duty of 0x14 and mode 2'b11, each period is 80 ticks with the output high for the first 20 ticks (25 percent).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 duty, 1 span, 2 control |
| wr_data | input | W | Write data; control uses bits 3:0 |
| pulse_out | output | 1 | Waveform output |

## Verification
The bench targets a duty write landing on the very edge of a span match, where a design that let the new value through at once would shorten or stretch the current pulse by one period's worth of change. It stops the counter mid-period and writes the duty holding register while stopped, so a design that kept transferring or kept toggling while idle would show a moved edge after restart. It sets the duty value equal to and above the span, where a design that compared against the unwrapped count would add a spurious second toggle, and it feeds a gapped tick stream, where a design that counted clocks instead of ticks would compress the waveform.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ppg_state_e;

    localparam logic [1:0] SEL_DUTY = 2'd0;
    localparam logic [1:0] SEL_SPAN = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CTL_RUN     = 0;
    localparam int CTL_DBUF    = 1;
    localparam int CTL_PRE_VAL = 2;
    localparam int CTL_PRE_EN  = 3;
    localparam int CTL_BITS    = 4;
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         span_hit,
    output logic [W-1:0] duty_act,
    output logic [W-1:0] span_q,
    output logic         run_q,
    output logic         tog_en,
    output logic         preset_stb,
    output logic         preset_val
);
    logic [W-1:0] duty_hold;
    logic         dbuf_q;
    logic [1:0]   mode_q;
    logic         wr_duty;
    logic         wr_span;
    logic         wr_ctrl;

    assign wr_duty = wr_en && (wr_sel == SEL_DUTY);
    assign wr_span = wr_en && (wr_sel == SEL_SPAN);
    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_hold <= '0;
            duty_act  <= '0;
            span_q    <= '0;
            run_q     <= 1'b0;
            dbuf_q    <= 1'b0;
            mode_q    <= 2'b00;
        end else begin
            if (wr_duty) begin
                duty_hold <= wr_data;
            end
            if (wr_duty && !dbuf_q) begin
                duty_act <= wr_data;
            end else if (span_hit) begin
                duty_act <= duty_hold;
            end
            if (wr_span) begin
                span_q <= wr_data;
            end
            if (wr_ctrl) begin
                run_q  <= wr_data[CTL_RUN];
                dbuf_q <= wr_data[CTL_DBUF];
                mode_q <= wr_data[CTL_PRE_EN:CTL_PRE_VAL];
            end
        end
    end

    assign tog_en     = mode_q[1];
    assign preset_stb = wr_ctrl && wr_data[CTL_PRE_EN];
    assign preset_val = wr_data[CTL_PRE_VAL];

    // R5
    duty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_duty && !span_hit) |=> $stable(duty_act));

    // R6
    duty_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_duty && !dbuf_q) |=> (duty_act == $past(wr_data)));
endmodule

// File: rtl/ppg_core.sv
module ppg_core
    import ppg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run_q,
    input  logic [W-1:0] duty_act,
    input  logic [W-1:0] span_q,
    output logic         span_hit,
    output logic         duty_hit,
    output logic         counting
);
    ppg_state_e   state_q;
    ppg_state_e   state_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;
    logic         span_eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = run_q ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = run_q ? ST_RUN : ST_IDLE;
        endcase
    end

    assign counting = (state_q == ST_RUN) && run_q;
    assign cnt_inc  = cnt_q + 1'b1;
    assign span_eq  = (cnt_inc == span_q);
    assign span_hit = counting && tick && span_eq;
    assign duty_hit = counting && tick && !span_eq && (cnt_inc == duty_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!counting) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= span_eq ? '0 : cnt_inc;
        end
    end

    // R4
    span_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        span_hit |=> (cnt_q == '0));

    // R8
    halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (cnt_q == '0));
endmodule

// File: rtl/ppg_outff.sv
module ppg_outff (
    input  logic clk,
    input  logic rst_n,
    input  logic preset_stb,
    input  logic preset_val,
    input  logic tog_en,
    input  logic span_hit,
    input  logic duty_hit,
    input  logic counting,
    output logic wave_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else if (preset_stb) begin
            wave_q <= preset_val;
        end else if (tog_en && (span_hit || duty_hit)) begin
            wave_q <= ~wave_q;
        end
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !preset_stb) |=> $stable(wave_q));

    // R7
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_stb |=> (wave_q == $past(preset_val)));
endmodule

// File: rtl/ppg_top.sv
module ppg_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         pulse_out
);
    logic [W-1:0] duty_act;
    logic [W-1:0] span_q;
    logic         run_q;
    logic         tog_en;
    logic         preset_stb;
    logic         preset_val;
    logic         span_hit;
    logic         duty_hit;
    logic         counting;

    ppg_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .span_hit   (span_hit),
        .duty_act   (duty_act),
        .span_q     (span_q),
        .run_q      (run_q),
        .tog_en     (tog_en),
        .preset_stb (preset_stb),
        .preset_val (preset_val)
    );

    ppg_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run_q    (run_q),
        .duty_act (duty_act),
        .span_q   (span_q),
        .span_hit (span_hit),
        .duty_hit (duty_hit),
        .counting (counting)
    );

    ppg_outff u_outff (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_stb (preset_stb),
        .preset_val (preset_val),
        .tog_en     (tog_en),
        .span_hit   (span_hit),
        .duty_hit   (duty_hit),
        .counting   (counting),
        .wave_q     (pulse_out)
    );

    // R10
    single_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({span_hit, duty_hit}));
endmodule

// File: tb/tb_ppg_top.sv
module tb_ppg_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct {
        logic  val;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         pulse_out;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    logic [W-1:0] m_hold = '0, m_act = '0, m_span = '0, m_cnt = '0;
    logic         m_run = 1'b0, m_dbuf = 1'b0, m_state = 1'b0, m_out = 1'b0;
    logic [1:0]   m_mode = 2'b00;

    ppg_top #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pulse_out (pulse_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: applies one cycle of stimulus, advances the requirement model, queues the expectation.
    task automatic step(input logic tk, input logic we, input logic [1:0] sel, input logic [W-1:0] d);
        logic         cnt_on, s_hit, d_hit;
        logic [W-1:0] inc;
        @(negedge clk);
        tick = tk; wr_en = we; wr_sel = sel; wr_data = d;
        cnt_on = m_state && m_run;
        inc    = m_cnt + 1'b1;
        s_hit  = cnt_on && tk && (inc == m_span);
        d_hit  = cnt_on && tk && (inc != m_span) && (inc == m_act);
        if (we && sel == 2'd2 && d[3]) m_out = d[2];
        else if (m_mode[1] && (s_hit || d_hit)) m_out = ~m_out;
        if (!cnt_on) m_cnt = '0;
        else if (tk) m_cnt = s_hit ? '0 : inc;
        m_state = m_run;
        if (we && sel == 2'd0 && !m_dbuf) m_act = d;
        else if (s_hit) m_act = m_hold;
        if (we && sel == 2'd0) m_hold = d;
        if (we && sel == 2'd1) m_span = d;
        if (we && sel == 2'd2) begin
            m_run = d[0]; m_dbuf = d[1]; m_mode = d[3:2];
        end
        @(posedge clk);
        #1;
        sb_q.push_back('{val: m_out, tag: cur_tag});
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
        step(1'b1, 1'b1, sel, d);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, '0);
    endtask

    // Monitor: compares the output against queued expectations away from the clock edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (pulse_out !== e.val) begin
                errors++;
                $display("FAIL %s: pulse_out=%0b expected=%0b at %0t", e.tag, pulse_out, e.val, $time);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (pulse_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: pulse_out=%0b expected=0 after reset", pulse_out);
        end
        rst_n = 1'b1;
        cur_tag = "R1";
        run(5);

        // 25 percent example: span 0x50, duty 0x14, preset 1 + toggle, run
        cur_tag = "R3 R4 R12";
        wr(2'd0, 8'h14);
        wr(2'd1, 8'h50);
        wr(2'd2, 8'h0D);
        run(170);

        // gapped ticks
        cur_tag = "R2";
        wr(2'd2, 8'h0C);
        wr(2'd1, 8'd10);
        wr(2'd0, 8'd3);
        wr(2'd2, 8'h0D);
        for (int i = 0; i < 60; i++) step(i[0], 1'b0, 2'd0, '0);
        for (int i = 0; i < 30; i++) step((i % 3) == 0, 1'b0, 2'd0, '0);

        // stop mid-period, hold, restart from zero
        cur_tag = "R8";
        run(4);
        wr(2'd2, 8'h0C);
        cur_tag = "R9";
        run(10);
        cur_tag = "R8";
        wr(2'd2, 8'h0D);
        run(25);

        // low-going pulse and toggling disabled
        cur_tag = "R7";
        wr(2'd2, 8'h08);
        wr(2'd2, 8'h09);
        run(25);
        wr(2'd2, 8'h01);
        run(25);

        // immediate duty update
        cur_tag = "R6";
        wr(2'd2, 8'h0C);
        wr(2'd2, 8'h0D);
        run(4);
        wr(2'd0, 8'd6);
        run(25);

        // buffered duty update
        cur_tag = "R5";
        wr(2'd2, 8'h0F);
        run(3);
        wr(2'd0, 8'd8);
        run(35);

        // duty write on the span match edge
        cur_tag = "R11";
        while (m_cnt != m_span - 1'b1) run(1);
        wr(2'd0, 8'd2);
        run(35);

        // stopped: no transfer, output held
        cur_tag = "R9";
        wr(2'd2, 8'h0E);
        wr(2'd0, 8'd5);
        run(10);
        wr(2'd2, 8'h0F);
        run(30);

        // duty at or beyond span
        cur_tag = "R10";
        wr(2'd2, 8'h0C);
        wr(2'd0, 8'd12);
        wr(2'd2, 8'h0D);
        run(35);
        wr(2'd0, 8'd10);
        run(35);

        run(2);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule